// File: doc/BRIEF.md
# Local Interrupt Selection Arbiter

This block decides which local interrupt a hart should take next. It keeps the hart's pending-interrupt register, which outside sources change through a masked read-modify-write port, and a small privilege-mode register. Each cycle it qualifies the pending bits with the per-source enable vector. It then gates every bit with one of two global enables. The delegation mask picks which enable applies to each bit, and the enable is judged against the current privilege level. It reports whether any interrupt is to be taken and, if so, the number of the lowest qualifying source.

The trap entry that consumes the result, the decode of control-register instructions and the platform interrupt controller sit outside the block. The enable vector, the delegation mask and the two global enable bits come in as plain inputs from the hart's control state. The result is registered, so consumers see it one clock after the state that produced it.

Top module: `irq_take_arb`

## Requirements
- R1: A source is a candidate only when its bit is set both in the pending register and in `irq_enable`. A pending bit whose enable bit is clear never produces `take_valid`.
- R2: The machine-level global enable is true when the current privilege is user (0) or supervisor (1). It is also true when the privilege is machine (3) and `m_ie` is 1. It is false when the privilege is machine and `m_ie` is 0.
- R3: The supervisor-level global enable is true when the privilege is user (0), or when it is supervisor (1) and `s_ie` is 1. It is false at machine privilege, whatever `s_ie` holds.
- R4: Candidate bits whose `irq_deleg` bit is 0 are gated by the machine-level enable. Candidate bits whose `irq_deleg` bit is 1 are gated by the supervisor-level enable. An interrupt is taken if either group leaves a bit set.
- R5: When several gated bits are set, `take_cause` is the index of the lowest-numbered one.
- R6: When no gated bit is set, `take_valid` is 0 and `take_cause` is 0.
- R7: With `pend_wr_en` high, the pending register becomes (old & ~`pend_wr_mask`) | (`pend_wr_data` & `pend_wr_mask`) at the clock edge. From the next cycle, `pend_old` shows the contents from before that write. Bits outside the mask keep their value.
- R8: Privilege is encoded user=0, supervisor=1, machine=3. A write of 2 through `priv_wr_en`/`priv_wr_data` is stored as 0 (user), and `priv_q` never shows 2.
- R9: `take_valid` and `take_cause` are registered. They reflect the inputs and register state of the previous clock cycle.
- R10: Reset clears the pending register and `pend_old`, sets the privilege to machine (3), and drives `take_valid` and `take_cause` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pend_wr_en | input | 1 | Apply a masked update to the pending register |
| pend_wr_mask | input | 32 | Bits of the pending register that the update replaces |
| pend_wr_data | input | 32 | New values for the masked bits |
| pend_old | output | 32 | Pending contents before the most recent update |
| pend_q | output | 32 | Current pending register |
| priv_wr_en | input | 1 | Write the privilege-mode register |
| priv_wr_data | input | 2 | Privilege to store (0 user, 1 supervisor, 3 machine) |
| priv_q | output | 2 | Current privilege level |
| irq_enable | input | 32 | Per-source enable vector |
| irq_deleg | input | 32 | Per-source delegation mask (1 = supervisor handles it) |
| m_ie | input | 1 | Machine-level global interrupt enable bit |
| s_ie | input | 1 | Supervisor-level global interrupt enable bit |
| take_valid | output | 1 | An interrupt should be taken |
| take_cause | output | 5 | Index of the selected source |

## Verification
The selection is driven with the same pending and enable pattern under each of the three privilege levels and all four settings of the two global enable bits. This separates the machine-level rule from the supervisor-level rule. One vector holding both delegated and non-delegated bits shows which group each privilege level lets through. A separate case puts a delegated bit below a non-delegated one, so the result shows whether gating happens before priority selection. Single-bit, multi-bit and top-bit patterns check the lowest-index choice at both ends of the vector. Overlapping masked writes show that bits outside the mask survive and that the previous contents are reported.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_t;

  function automatic int unsigned clog2_min1(input int unsigned n);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < n) r++;
    if (r == 0) r = 1;
    return r;
  endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] old_q
);

  logic [W-1:0] pend_d;
  logic [W-1:0] old_d;

  always_comb begin
    pend_d = pend_q;
    old_d  = old_q;
    if (wr_en) begin
      pend_d = (pend_q & ~wr_mask) | (wr_data & wr_mask);
      old_d  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      old_q  <= '0;
    end else if (wr_en) begin
      pend_q <= pend_d;
      old_q  <= old_d;
    end
  end

  // R7: unmasked bits survive an update
  p_unmasked_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((pend_q & ~$past(wr_mask)) == ($past(pend_q) & ~$past(wr_mask))));

  // R7: old contents reported after an update
  p_old_reported_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (old_q == $past(pend_q)));

  // R7: no write, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_q));

endmodule

// File: rtl/irq_priv_reg.sv
module irq_priv_reg
  import irq_take_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output priv_t      priv_q
);

  priv_t priv_d;

  always_comb begin
    priv_d = priv_q;
    if (wr_en) begin
      if (wr_data == 2'd2) priv_d = PRIV_USER;
      else                 priv_d = priv_t'(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      priv_q <= PRIV_MACH;
    else if (wr_en)  priv_q <= priv_d;
  end

  // R8: reserved level never held
  p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSVD);

  // R8: a write of the reserved level lands on user
  p_rsvd_to_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 2'd2) |=> (priv_q == PRIV_USER));

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_take_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] enable,
  input  logic [W-1:0] deleg,
  input  priv_t        priv,
  input  logic         m_ie,
  input  logic         s_ie,
  output logic [W-1:0] gated
);

  logic         m_glob;
  logic         s_glob;
  logic [W-1:0] cand;

  always_comb begin
    m_glob = (priv != PRIV_MACH) || m_ie;
    s_glob = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_ie);
    cand   = pend & enable;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gated[i] = cand[i] & (deleg[i] ? s_glob : m_glob);
  end

endmodule

// File: rtl/irq_lowest_idx.sv
module irq_lowest_idx
  import irq_take_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = clog2_min1(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [CW-1:0] idx
);

  logic [W-1:0] low_oh;

  always_comb begin
    low_oh = vec & (~vec + {{(W-1){1'b0}}, 1'b1});
    any    = |vec;
  end

  for (genvar b = 0; b < CW; b++) begin : g_enc
    logic [W-1:0] sel;
    for (genvar i = 0; i < W; i++) begin : g_sel
      localparam int unsigned IB = i;
      assign sel[i] = IB[b];
    end
    assign idx[b] = |(low_oh & sel);
  end

endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb
  import irq_take_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = clog2_min1(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_wr_en,
  input  logic [W-1:0]  pend_wr_mask,
  input  logic [W-1:0]  pend_wr_data,
  output logic [W-1:0]  pend_old,
  output logic [W-1:0]  pend_q,
  input  logic          priv_wr_en,
  input  logic [1:0]    priv_wr_data,
  output logic [1:0]    priv_q,
  input  logic [W-1:0]  irq_enable,
  input  logic [W-1:0]  irq_deleg,
  input  logic          m_ie,
  input  logic          s_ie,
  output logic          take_valid,
  output logic [CW-1:0] take_cause
);

  logic          rst_meta;
  logic          rst_sync_n;
  priv_t         priv_cur;
  logic [W-1:0]  gated;
  logic          sel_any;
  logic [CW-1:0] sel_idx;
  logic          valid_d;
  logic [CW-1:0] cause_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  irq_pend_reg #(.W(W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (pend_wr_en),
    .wr_mask (pend_wr_mask),
    .wr_data (pend_wr_data),
    .pend_q  (pend_q),
    .old_q   (pend_old)
  );

  irq_priv_reg u_priv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (priv_wr_en),
    .wr_data (priv_wr_data),
    .priv_q  (priv_cur)
  );

  assign priv_q = priv_cur;

  irq_gate #(.W(W)) u_gate (
    .pend   (pend_q),
    .enable (irq_enable),
    .deleg  (irq_deleg),
    .priv   (priv_cur),
    .m_ie   (m_ie),
    .s_ie   (s_ie),
    .gated  (gated)
  );

  irq_lowest_idx #(.W(W), .CW(CW)) u_low (
    .vec (gated),
    .any (sel_any),
    .idx (sel_idx)
  );

  always_comb begin
    valid_d = sel_any;
    cause_d = sel_any ? sel_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take_valid <= 1'b0;
      take_cause <= '0;
    end else begin
      take_valid <= valid_d;
      take_cause <= cause_d;
    end
  end

  // R5: the reported cause was a gated bit one cycle earlier
  p_cause_is_set_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_valid |-> ((($past(gated) >> take_cause) & 1) == 1));

  // R5: nothing lower than the cause was gated
  p_cause_lowest_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_valid |-> (($past(gated) & ((W'(1) << take_cause) - W'(1))) == '0));

  // R6: idle output carries cause zero
  p_idle_cause_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !take_valid |-> (take_cause == '0));

  // R3 R4: at machine level delegated bits never pass
  p_mach_blocks_deleg_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (priv_cur == PRIV_MACH) |-> ((gated & irq_deleg) == '0));

  // R2: machine level with m_ie low passes nothing undelegated
  p_mach_masked_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (priv_cur == PRIV_MACH && !m_ie) |-> ((gated & ~irq_deleg) == '0));

  // R1: nothing passes without enable
  p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((gated & ~irq_enable) == '0));

endmodule

// File: tb/irq_take_arb_test.sv
module irq_take_arb_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pend_wr_en;
  logic [31:0] pend_wr_mask;
  logic [31:0] pend_wr_data;
  logic [31:0] pend_old;
  logic [31:0] pend_q;
  logic        priv_wr_en;
  logic [1:0]  priv_wr_data;
  logic [1:0]  priv_q;
  logic [31:0] irq_enable;
  logic [31:0] irq_deleg;
  logic        m_ie;
  logic        s_ie;
  logic        take_valid;
  logic [4:0]  take_cause;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] sw_pend;
  logic [1:0]  sw_priv;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_take_arb uut (
    .clk(clk), .rst_n(rst_n),
    .pend_wr_en(pend_wr_en), .pend_wr_mask(pend_wr_mask), .pend_wr_data(pend_wr_data),
    .pend_old(pend_old), .pend_q(pend_q),
    .priv_wr_en(priv_wr_en), .priv_wr_data(priv_wr_data), .priv_q(priv_q),
    .irq_enable(irq_enable), .irq_deleg(irq_deleg), .m_ie(m_ie), .s_ie(s_ie),
    .take_valid(take_valid), .take_cause(take_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model(input logic [31:0] p, input logic [31:0] en,
                                       input logic [31:0] dl, input logic [1:0] pr,
                                       input logic mi, input logic si);
    logic mg, sg;
    logic [31:0] g;
    mg = (pr == 2'd0) || (pr == 2'd1) || (pr == 2'd3 && mi);
    sg = (pr == 2'd0) || (pr == 2'd1 && si);
    g = '0;
    for (int i = 0; i < 32; i++) begin
      if (p[i] && en[i]) g[i] = dl[i] ? sg : mg;
    end
    for (int i = 0; i < 32; i++) begin
      if (g[i]) return {1'b1, 5'(i)};
    end
    return 6'd0;
  endfunction

  task automatic wr_pend(input logic [31:0] mask, input logic [31:0] val);
    @(negedge clk);
    pend_wr_en = 1'b1; pend_wr_mask = mask; pend_wr_data = val;
    @(negedge clk);
    pend_wr_en = 1'b0;
    sw_pend = (sw_pend & ~mask) | (val & mask);
  endtask

  task automatic wr_priv(input logic [1:0] v);
    @(negedge clk);
    priv_wr_en = 1'b1; priv_wr_data = v;
    @(negedge clk);
    priv_wr_en = 1'b0;
    sw_priv = (v == 2'd2) ? 2'd0 : v;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_take(input string req);
    logic [5:0] e;
    e = model(sw_pend, irq_enable, irq_deleg, sw_priv, m_ie, s_ie);
    check({req, " valid"}, {31'd0, take_valid}, {31'd0, e[5]});
    check({req, " cause"}, {27'd0, take_cause}, {27'd0, e[4:0]});
  endtask

  task automatic test_reset();
    check("R10 pending", pend_q, 32'd0);
    check("R10 old", pend_old, 32'd0);
    check("R10 priv", {30'd0, priv_q}, 32'd3);
    check("R10 valid", {31'd0, take_valid}, 32'd0);
    check("R10 cause", {27'd0, take_cause}, 32'd0);
  endtask

  task automatic test_candidate_and();
    irq_deleg = '0; m_ie = 1'b1; s_ie = 1'b0;
    irq_enable = 32'h0000_00F0;
    wr_pend(32'hFFFF_FFFF, 32'h0000_000F);
    settle();
    check("R1 disabled pending ignored", {31'd0, take_valid}, 32'd0);
    irq_enable = 32'h0000_0004;
    settle();
    check("R1 enabled bit taken", {27'd0, take_cause}, 32'd2);
    expect_take("R1");
  endtask

  task automatic test_m_enable();
    irq_deleg = '0; irq_enable = '1;
    wr_pend('1, 32'h0000_0080);
    wr_priv(2'd3); m_ie = 1'b0; s_ie = 1'b1; settle();
    check("R2 machine mie=0 blocks", {31'd0, take_valid}, 32'd0);
    m_ie = 1'b1; settle();
    check("R2 machine mie=1 takes", {31'd0, take_valid}, 32'd1);
    expect_take("R2 machine");
    wr_priv(2'd1); m_ie = 1'b0; s_ie = 1'b0; settle();
    check("R2 supervisor ignores mie", {31'd0, take_valid}, 32'd1);
    wr_priv(2'd0); settle();
    expect_take("R2 user");
  endtask

  task automatic test_s_enable();
    irq_deleg = '1; irq_enable = '1; m_ie = 1'b1;
    wr_pend('1, 32'h0000_0200);
    wr_priv(2'd1); s_ie = 1'b0; settle();
    check("R3 supervisor sie=0 blocks", {31'd0, take_valid}, 32'd0);
    s_ie = 1'b1; settle();
    check("R3 supervisor sie=1 takes", {27'd0, take_cause}, 32'd9);
    wr_priv(2'd0); s_ie = 1'b0; settle();
    check("R3 user ignores sie", {31'd0, take_valid}, 32'd1);
    wr_priv(2'd3); s_ie = 1'b1; settle();
    check("R3 machine never takes delegated", {31'd0, take_valid}, 32'd0);
    expect_take("R3 machine");
  endtask

  task automatic test_deleg_split();
    irq_enable = '1; irq_deleg = 32'h0000_0002;
    wr_pend('1, 32'h0000_0022);
    wr_priv(2'd3); m_ie = 1'b1; s_ie = 1'b1; settle();
    check("R4 machine picks undelegated", {27'd0, take_cause}, 32'd5);
    wr_priv(2'd1); s_ie = 1'b1; settle();
    check("R4 supervisor picks delegated low", {27'd0, take_cause}, 32'd1);
    s_ie = 1'b0; settle();
    check("R4 sie=0 falls to undelegated", {27'd0, take_cause}, 32'd5);
    expect_take("R4");
  endtask

  task automatic test_priority();
    irq_enable = '1; irq_deleg = '0; m_ie = 1'b1;
    wr_priv(2'd3);
    wr_pend('1, 32'h8000_0000); settle();
    check("R5 top bit", {27'd0, take_cause}, 32'd31);
    wr_pend('1, 32'h8001_1000); settle();
    check("R5 lowest of three", {27'd0, take_cause}, 32'd12);
    wr_pend('1, 32'hFFFF_FFFF); settle();
    check("R5 all set gives 0", {27'd0, take_cause}, 32'd0);
    check("R5 all set valid", {31'd0, take_valid}, 32'd1);
  endtask

  task automatic test_none();
    wr_pend('1, 32'h0000_0000); settle();
    check("R6 no pending valid", {31'd0, take_valid}, 32'd0);
    check("R6 no pending cause", {27'd0, take_cause}, 32'd0);
  endtask

  task automatic test_masked_update();
    wr_pend('1, 32'hA5A5_0000);
    wr_pend(32'h0000_FFFF, 32'hFFFF_1234);
    check("R7 masked write low", pend_q, 32'hA5A5_1234);
    check("R7 old contents", pend_old, 32'hA5A5_0000);
    wr_pend(32'hFF00_0000, 32'h0000_0000);
    check("R7 clear field", pend_q, 32'h00A5_1234);
    check("R7 old again", pend_old, 32'hA5A5_1234);
    check("R7 model", pend_q, sw_pend);
  endtask

  task automatic test_priv_reserved();
    wr_priv(2'd2);
    check("R8 reserved stored as user", {30'd0, priv_q}, 32'd0);
    wr_priv(2'd1);
    check("R8 supervisor stored", {30'd0, priv_q}, 32'd1);
  endtask

  task automatic test_latency();
    irq_enable = '1; irq_deleg = '0; m_ie = 1'b1;
    wr_priv(2'd3);
    wr_pend('1, 32'h0000_0010); settle();
    check("R9 before change", {27'd0, take_cause}, 32'd4);
    @(negedge clk);
    irq_enable = 32'h0000_0000;
    #1;
    check("R9 no same-cycle change", {31'd0, take_valid}, 32'd1);
    @(negedge clk);
    check("R9 one cycle later", {31'd0, take_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    pend_wr_en = 1'b0; pend_wr_mask = '0; pend_wr_data = '0;
    priv_wr_en = 1'b0; priv_wr_data = '0;
    irq_enable = '0; irq_deleg = '0; m_ie = 1'b0; s_ie = 1'b0;
    sw_pend = '0; sw_priv = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_candidate_and();
    test_m_enable();
    test_s_enable();
    test_deleg_split();
    test_priority();
    test_none();
    test_masked_update();
    test_priv_reserved();
    test_latency();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule